// File: doc/BRIEF.md
# Coincident-Selection Bit-Cell RAM

This block is a small random access memory that holds one bit per word. The cells sit in a grid of rows and columns. A cell is picked when one row line and one column line are both active. A short row decoder drives the row lines from the upper address bits. A short column decoder drives the column lines from the lower address bits. This replaces a single wide word decoder. With the default parameters the grid is 4x4, which gives 16 one-bit words.

Each column has one read/write slice shared by every cell in that column. Chip select enables only the column decoder. When the chip is deselected, no column is active, so nothing is read and nothing is written. The data output passes through a three-state stage, and `dout_oe` brings out that stage's enable. Several copies can therefore share one output line behind a decoder of higher-order address bits, with address, data and read/write wired in parallel. Storage is flip-flops written on the rising clock edge.

Top module: `grid_bitram`

## Requirements
- R1: Address bits [3:2] choose the row and bits [1:0] choose the column, so the cell index is 4*row + column. Two addresses with row and column swapped (6 and 9) refer to different cells.
- R2: With `cs`=1 and `rw`=1 (write), `din` is stored into the addressed cell on the rising edge of `clk`. No other cell changes.
- R3: With `cs`=0, no column is selected and no cell is written, even when `rw`=1.
- R4: With `cs`=1 and `rw`=0 (read), `dout_oe` is 1 and `dout` shows the addressed cell in the same cycle, with no clock edge needed.
- R5: During a write, or while `cs`=0, `dout_oe` is 0 and `dout` is high impedance.
- R6: A synchronous active-high `rst` clears every cell to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all cells |
| cs | input | 1 | Chip select, enables the column decoder |
| rw | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Address: row in upper bits, column in lower bits |
| din | input | 1 | Data bit to write |
| dout | output | 1 | Read data bit, high impedance when not driven |
| dout_oe | output | 1 | Enable of the three-state output stage |

## Verification
The bench builds the block with its default geometry of two row bits and two column bits. This makes the grid small enough to write and read back every one of the 16 cells with a distinct pattern. With this geometry the row/column swap at addresses 6 and 9, and the corner cells 0, 3, 12 and 15, are each addressable directly. Deselected writes and writes to neighbouring cells are each followed by reads of the cells they could have disturbed.

// File: rtl/grid_bitram_pkg.sv
package grid_bitram_pkg;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    typedef struct packed {
        logic sel;
        logic wr;
        logic din;
    } slice_ctl_t;

    function automatic int grid_cells(input int rbits, input int cbits);
        return (1 << rbits) * (1 << cbits);
    endfunction

endpackage

// File: rtl/bitram_decoder.sv
module bitram_decoder #(
    parameter int IN_W = 2,
    localparam int OUTS = 1 << IN_W
) (
    input  logic            en,
    input  logic [IN_W-1:0] code,
    output logic [OUTS-1:0] sel
);
    for (genvar i = 0; i < OUTS; i++) begin : g_line
        assign sel[i] = en && (code == IN_W'(i));
    end
endmodule

// File: rtl/bitram_column.sv
module bitram_column
    import grid_bitram_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ROWS-1:0] row_sel,
    input  slice_ctl_t      ctl,
    output logic            rd_bit
);
    logic [ROWS-1:0] cells;

    for (genvar r = 0; r < ROWS; r++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[r] <= 1'b0;
            else if (ctl.sel && ctl.wr && row_sel[r])
                cells[r] <= ctl.din;
        end
    end

    assign rd_bit = ctl.sel && !ctl.wr && (|(row_sel & cells));
endmodule

// File: rtl/grid_bitram.sv
module grid_bitram
    import grid_bitram_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    localparam int ADDR_W = ROW_BITS + COL_BITS,
    localparam int ROWS   = 1 << ROW_BITS,
    localparam int COLS   = 1 << COL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe
);
    logic [ROWS-1:0] row_sel;
    logic [COLS-1:0] col_sel;
    logic [COLS-1:0] col_rd;
    logic            rd_bit;
    logic            is_write;

    assign is_write = (acc_e'(rw) == ACC_WRITE);

    bitram_decoder #(.IN_W(ROW_BITS)) u_row_dec (
        .en   (1'b1),
        .code (addr[ADDR_W-1:COL_BITS]),
        .sel  (row_sel)
    );

    bitram_decoder #(.IN_W(COL_BITS)) u_col_dec (
        .en   (cs),
        .code (addr[COL_BITS-1:0]),
        .sel  (col_sel)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_col
        slice_ctl_t ctl;
        assign ctl.sel = col_sel[c];
        assign ctl.wr  = is_write;
        assign ctl.din = din;
        bitram_column #(.ROWS(ROWS)) u_slice (
            .clk     (clk),
            .rst     (rst),
            .row_sel (row_sel),
            .ctl     (ctl),
            .rd_bit  (col_rd[c])
        );
    end

    assign rd_bit  = |col_rd;
    assign dout_oe = cs && !is_write;
    assign dout    = dout_oe ? rd_bit : 1'bz;
endmodule

// File: rtl/grid_bitram_chk.sv
module grid_bitram_chk #(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    localparam int ADDR_W = ROW_BITS + COL_BITS,
    localparam int ROWS   = 1 << ROW_BITS,
    localparam int COLS   = 1 << COL_BITS,
    localparam int CELLS  = ROWS * COLS
) (
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              rw,
    input logic [ADDR_W-1:0] addr,
    input logic              din,
    input logic              dout_oe,
    input logic              rd_bit,
    input logic [ROWS-1:0]   row_sel,
    input logic [COLS-1:0]   col_sel
);
    logic [CELLS-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst)
            shadow <= '0;
        else if (cs && rw)
            shadow[addr] <= din;
    end

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(row_sel) && row_sel[addr[ADDR_W-1:COL_BITS]]); // R1

    AST_COL_PICK: assert property (@(posedge clk) disable iff (rst)
        cs |-> ($onehot(col_sel) && col_sel[addr[COL_BITS-1:0]])); // R1

    AST_COL_GATED: assert property (@(posedge clk) disable iff (rst)
        !cs |-> (col_sel == '0)); // R3

    AST_READ_DATA: assert property (@(posedge clk) disable iff (rst)
        (cs && !rw) |-> (rd_bit == shadow[addr])); // R2

    AST_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!cs || rw) |-> !dout_oe); // R5

    AST_READ_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (cs && !rw) |-> dout_oe); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && cs && !rw) |-> !rd_bit); // R6
endmodule

bind grid_bitram grid_bitram_chk #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .rw      (rw),
    .addr    (addr),
    .din     (din),
    .dout_oe (dout_oe),
    .rd_bit  (rd_bit),
    .row_sel (row_sel),
    .col_sel (col_sel)
);

// File: tb/grid_bitram_test.sv
module grid_bitram_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0;
    logic       rw = 1'b0;
    logic [3:0] addr = '0;
    logic       din = 1'b0;
    logic       dout;
    logic       dout_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    grid_bitram uut (
        .clk     (clk),
        .rst     (rst),
        .cs      (cs),
        .rw      (rw),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    // {cs, rw, addr, din, exp_oe, exp_dout, req}
    typedef struct packed {
        logic       cs;
        logic       rw;
        logic [3:0] addr;
        logic       din;
        logic       eoe;
        logic       edo;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 4'd0,  1'b0, 1'b1, 1'b0, 4'd6},
        '{1'b1, 1'b1, 4'd5,  1'b1, 1'b0, 1'b0, 4'd5},
        '{1'b1, 1'b0, 4'd5,  1'b0, 1'b1, 1'b1, 4'd2},
        '{1'b1, 1'b0, 4'd4,  1'b0, 1'b1, 1'b0, 4'd2},
        '{1'b1, 1'b0, 4'd6,  1'b0, 1'b1, 1'b0, 4'd2},
        '{1'b1, 1'b0, 4'd1,  1'b0, 1'b1, 1'b0, 4'd2},
        '{1'b1, 1'b0, 4'd9,  1'b0, 1'b1, 1'b0, 4'd2},
        '{1'b1, 1'b1, 4'd15, 1'b1, 1'b0, 1'b0, 4'd5},
        '{1'b1, 1'b0, 4'd15, 1'b0, 1'b1, 1'b1, 4'd2},
        '{1'b1, 1'b0, 4'd12, 1'b0, 1'b1, 1'b0, 4'd1},
        '{1'b1, 1'b0, 4'd3,  1'b0, 1'b1, 1'b0, 4'd1},
        '{1'b1, 1'b1, 4'd0,  1'b1, 1'b0, 1'b0, 4'd5},
        '{1'b1, 1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'd4},
        '{1'b0, 1'b1, 4'd10, 1'b1, 1'b0, 1'b0, 4'd5},
        '{1'b1, 1'b0, 4'd10, 1'b0, 1'b1, 1'b0, 4'd3},
        '{1'b0, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0, 4'd5},
        '{1'b1, 1'b1, 4'd5,  1'b0, 1'b0, 1'b0, 4'd5},
        '{1'b1, 1'b0, 4'd5,  1'b0, 1'b1, 1'b0, 4'd2},
        '{1'b1, 1'b0, 4'd15, 1'b0, 1'b1, 1'b1, 4'd2},
        '{1'b1, 1'b1, 4'd6,  1'b1, 1'b0, 1'b0, 4'd5},
        '{1'b1, 1'b0, 4'd9,  1'b0, 1'b1, 1'b0, 4'd1},
        '{1'b1, 1'b0, 4'd6,  1'b0, 1'b1, 1'b1, 4'd1},
        '{1'b0, 1'b1, 4'd6,  1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 1'b0, 4'd6,  1'b0, 1'b1, 1'b1, 4'd3},
        '{1'b1, 1'b1, 4'd2,  1'b1, 1'b0, 1'b0, 4'd5},
        '{1'b1, 1'b0, 4'd2,  1'b0, 1'b1, 1'b1, 4'd4}
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (addr %0d)", req, act, exp, addr);
        end
    endtask

    task automatic apply(input logic c, input logic w, input logic [3:0] a, input logic d);
        @(negedge clk);
        cs = c; rw = w; addr = a; din = d;
        #1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        apply(1'b0, 1'b0, 4'd0, 1'b0);
        check("R5 reset idle oe", dout_oe, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].cs, VEC[i].rw, VEC[i].addr, VEC[i].din);
            check($sformatf("R%0d vec%0d oe", VEC[i].req, i), dout_oe, VEC[i].eoe);
            if (VEC[i].eoe)
                check($sformatf("R%0d vec%0d data", VEC[i].req, i), dout, VEC[i].edo);
        end

        // R1 R2: distinct pattern over every cell, index = 4*row + col
        for (int i = 0; i < 16; i++)
            apply(1'b1, 1'b1, 4'(i), 1'((i * 5 + 1) % 3 == 0));
        for (int i = 0; i < 16; i++) begin
            apply(1'b1, 1'b0, 4'(i), 1'b0);
            check("R1 full pattern", dout, 1'((i * 5 + 1) % 3 == 0));
        end

        // R3: deselected writes of inverted data leave contents intact
        for (int i = 0; i < 16; i++)
            apply(1'b0, 1'b1, 4'(i), 1'((i * 5 + 1) % 3 != 0));
        for (int i = 0; i < 16; i++) begin
            apply(1'b1, 1'b0, 4'(i), 1'b0);
            check("R3 deselected write ignored", dout, 1'((i * 5 + 1) % 3 == 0));
        end

        // R6: synchronous reset clears every cell
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) begin
            apply(1'b1, 1'b0, 4'(i), 1'b0);
            check("R6 cleared", dout, 1'b0);
            check("R4 read drives", dout_oe, 1'b1);
        end

        finish_run();
    end
endmodule